// File: doc/BRIEF.md
# Oldest-First Four-Wide Issue Queue

This block is the scheduling buffer between register rename and the integer ALUs of an out-of-order core. Rename writes up to four instructions per cycle into it. Each instruction carries an opcode, a program counter, a destination physical tag and two source operands. Each operand is either already holding its value or waiting on a physical tag. Four result buses broadcast a tag and a 64-bit value every cycle. A waiting operand whose tag appears on one of them takes that value.

In every cycle the queue picks up to four entries whose operands are complete and hands them to four ALU lanes. A result broadcast in the same cycle counts as complete, and its value is bypassed into the issued operation. When more than four entries could go, the ones with the smallest program counters win. The queue reports how many entries rename may fill. A flush from the exception logic empties the queue.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt` equals 32 and no issue lane is valid.
- R2: Each valid dispatch lane not under flush is stored in one free entry at the clock edge. The number of filled entries rises by the number of accepted lanes, and rename never offers more lanes than `free_cnt`.
- R3: An issued operation carries the stored opcode, PC, destination tag and operand values unchanged. The opcode codes are 0 add, 1 sub, 2 mulu, 3 divu and 4 remu. For an immediate form, rename supplies operand B already marked ready with the sign-extended immediate.
- R4: At most four operations issue per cycle. Valid lanes are packed from lane 0 upward, and the issued entries are the ready ones with the smallest PCs, in rising PC order across the lanes.
- R5: An entry with a missing operand whose tag matches a valid broadcast in the current cycle may issue in that cycle, using the broadcast value.
- R6: A waiting entry that matches a broadcast but is not selected keeps the captured value and marks the operand ready. It issues later with that value.
- R7: A dispatched operand whose tag matches a broadcast in its dispatch cycle is stored ready with the broadcast value.
- R8: An issued entry is removed at the next clock edge and never issues again.
- R9: `free_cnt` equals 32 minus the filled entries plus the entries issuing this cycle. A full queue that issues can therefore accept that many new entries in the same cycle.
- R10: While `flush` is high, no lane issues and dispatch is ignored. In the cycle after a flush the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties the queue, suppresses issue and dispatch |
| disp_valid | input | 4 | Dispatch lane valid |
| disp_op | input | 4x3 | Opcode per lane |
| disp_pc | input | 4x16 | Program counter per lane |
| disp_dst | input | 4x6 | Destination physical tag per lane |
| disp_a_rdy | input | 4 | Operand A holds its value |
| disp_a_tag | input | 4x6 | Operand A producer tag |
| disp_a_val | input | 4x64 | Operand A value |
| disp_b_rdy | input | 4 | Operand B holds its value |
| disp_b_tag | input | 4x6 | Operand B producer tag |
| disp_b_val | input | 4x64 | Operand B value or immediate |
| bc_valid | input | 4 | Result broadcast valid |
| bc_tag | input | 4x6 | Broadcast destination tag |
| bc_val | input | 4x64 | Broadcast result value |
| iss_valid | output | 4 | Issue lane valid |
| iss_op | output | 4x3 | Issued opcode |
| iss_pc | output | 4x16 | Issued PC |
| iss_dst | output | 4x6 | Issued destination tag |
| iss_a_val | output | 4x64 | Issued operand A |
| iss_b_val | output | 4x64 | Issued operand B |
| free_cnt | output | 6 | Entries rename may fill this cycle |

## Verification
A lost or duplicated valid bit shows up in `free_cnt` in the next cycle. It shows up again as a missing or repeated PC on the issue lanes as soon as that entry becomes ready. A missed capture makes the entry wait forever, or issue with a stale operand value on the first cycle it is picked. A wrong age comparison becomes visible only in a cycle with more than four ready entries, so the bench builds that case on purpose and also meets it often in the random traffic.

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int XLEN  = 64,
  parameter int TAGW  = 6,
  parameter int PCW   = 16,
  parameter int OPW   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [LANES-1:0]            disp_valid,
  input  logic [LANES-1:0][OPW-1:0]   disp_op,
  input  logic [LANES-1:0][PCW-1:0]   disp_pc,
  input  logic [LANES-1:0][TAGW-1:0]  disp_dst,
  input  logic [LANES-1:0]            disp_a_rdy,
  input  logic [LANES-1:0][TAGW-1:0]  disp_a_tag,
  input  logic [LANES-1:0][XLEN-1:0]  disp_a_val,
  input  logic [LANES-1:0]            disp_b_rdy,
  input  logic [LANES-1:0][TAGW-1:0]  disp_b_tag,
  input  logic [LANES-1:0][XLEN-1:0]  disp_b_val,
  input  logic [LANES-1:0]            bc_valid,
  input  logic [LANES-1:0][TAGW-1:0]  bc_tag,
  input  logic [LANES-1:0][XLEN-1:0]  bc_val,
  output logic [LANES-1:0]            iss_valid,
  output logic [LANES-1:0][OPW-1:0]   iss_op,
  output logic [LANES-1:0][PCW-1:0]   iss_pc,
  output logic [LANES-1:0][TAGW-1:0]  iss_dst,
  output logic [LANES-1:0][XLEN-1:0]  iss_a_val,
  output logic [LANES-1:0][XLEN-1:0]  iss_b_val,
  output logic [$clog2(DEPTH+1)-1:0]  free_cnt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [DEPTH-1:0] q_v, q_ar, q_br;
  logic [OPW-1:0]   q_op  [DEPTH];
  logic [PCW-1:0]   q_pc  [DEPTH];
  logic [TAGW-1:0]  q_dst [DEPTH];
  logic [TAGW-1:0]  q_at  [DEPTH];
  logic [TAGW-1:0]  q_bt  [DEPTH];
  logic [XLEN-1:0]  q_av  [DEPTH];
  logic [XLEN-1:0]  q_bv  [DEPTH];

  logic [DEPTH-1:0] a_hit, b_hit, cand, iss_sel, slot_free, wr_en;
  logic [XLEN-1:0]  a_cur [DEPTH];
  logic [XLEN-1:0]  b_cur [DEPTH];
  logic [CW-1:0]    rank  [DEPTH];
  logic [CW-1:0]    fidx  [DEPTH];
  logic [LW-1:0]    wr_lane [DEPTH];
  logic [CW-1:0]    occ, n_iss;

  logic [LANES-1:0] acc, d_ar, d_br;
  logic [XLEN-1:0]  d_av [LANES];
  logic [XLEN-1:0]  d_bv [LANES];
  logic [CW-1:0]    lord [LANES];

  assign acc = disp_valid & ~{LANES{flush}};

  // operand wake-up from the broadcast buses, for stored entries
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      a_hit[i] = 1'b0;
      b_hit[i] = 1'b0;
      a_cur[i] = q_av[i];
      b_cur[i] = q_bv[i];
      for (int l = 0; l < LANES; l++) begin
        if (bc_valid[l] && !q_ar[i] && bc_tag[l] == q_at[i]) begin
          a_hit[i] = 1'b1;
          a_cur[i] = bc_val[l];
        end
        if (bc_valid[l] && !q_br[i] && bc_tag[l] == q_bt[i]) begin
          b_hit[i] = 1'b1;
          b_cur[i] = bc_val[l];
        end
      end
      cand[i] = q_v[i] && (q_ar[i] || a_hit[i]) && (q_br[i] || b_hit[i]) && !flush;
    end
  end

  // age rank among ready entries: how many ready entries are older
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (cand[j] && j != i &&
            (q_pc[j] < q_pc[i] || (q_pc[j] == q_pc[i] && j < i)))
          rank[i] = rank[i] + CW'(1);
      end
      iss_sel[i] = cand[i] && (rank[i] < CW'(LANES));
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      iss_valid[k] = 1'b0;
      iss_op[k]    = '0;
      iss_pc[k]    = '0;
      iss_dst[k]   = '0;
      iss_a_val[k] = '0;
      iss_b_val[k] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (iss_sel[i] && rank[i] == CW'(k)) begin
          iss_valid[k] = 1'b1;
          iss_op[k]    = q_op[i];
          iss_pc[k]    = q_pc[i];
          iss_dst[k]   = q_dst[i];
          iss_a_val[k] = a_cur[i];
          iss_b_val[k] = b_cur[i];
        end
      end
    end
  end

  always_comb begin
    occ   = '0;
    n_iss = '0;
    for (int i = 0; i < DEPTH; i++) begin
      occ   = occ + CW'(q_v[i]);
      n_iss = n_iss + CW'(iss_sel[i]);
    end
  end

  assign free_cnt = CW'(DEPTH) - occ + n_iss;

  // dispatch lanes: capture same-cycle broadcasts and compute lane order
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      d_ar[l] = disp_a_rdy[l];
      d_br[l] = disp_b_rdy[l];
      d_av[l] = disp_a_val[l];
      d_bv[l] = disp_b_val[l];
      lord[l] = '0;
      for (int m = 0; m < l; m++) lord[l] = lord[l] + CW'(acc[m]);
      for (int b = 0; b < LANES; b++) begin
        if (!disp_a_rdy[l] && bc_valid[b] && bc_tag[b] == disp_a_tag[l]) begin
          d_ar[l] = 1'b1;
          d_av[l] = bc_val[b];
        end
        if (!disp_b_rdy[l] && bc_valid[b] && bc_tag[b] == disp_b_tag[l]) begin
          d_br[l] = 1'b1;
          d_bv[l] = bc_val[b];
        end
      end
    end
  end

  // slot allocation: n-th accepted lane goes to the n-th free slot
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_free[i] = !q_v[i] || iss_sel[i];
      fidx[i] = '0;
      for (int j = 0; j < i; j++) fidx[i] = fidx[i] + CW'(slot_free[j]);
      wr_en[i]   = 1'b0;
      wr_lane[i] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (slot_free[i] && acc[l] && lord[l] == fidx[i]) begin
          wr_en[i]   = 1'b1;
          wr_lane[i] = LW'(l);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v  <= '0;
      q_ar <= '0;
      q_br <= '0;
    end else if (flush) begin
      q_v <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en[i]) begin
          q_v[i]  <= 1'b1;
          q_ar[i] <= d_ar[wr_lane[i]];
          q_br[i] <= d_br[wr_lane[i]];
        end else begin
          if (iss_sel[i]) q_v[i]  <= 1'b0;
          if (a_hit[i])   q_ar[i] <= 1'b1;
          if (b_hit[i])   q_br[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i] && !flush) begin
        q_op[i]  <= disp_op[wr_lane[i]];
        q_pc[i]  <= disp_pc[wr_lane[i]];
        q_dst[i] <= disp_dst[wr_lane[i]];
        q_at[i]  <= disp_a_tag[wr_lane[i]];
        q_bt[i]  <= disp_b_tag[wr_lane[i]];
        q_av[i]  <= d_av[wr_lane[i]];
        q_bv[i]  <= d_bv[wr_lane[i]];
      end else begin
        if (a_hit[i]) q_av[i] <= a_cur[i];
        if (b_hit[i]) q_bv[i] <= b_cur[i];
      end
    end
  end

  logic armed;
  logic [CW-1:0] n_acc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  always_comb begin
    n_acc = '0;
    for (int l = 0; l < LANES; l++) n_acc = n_acc + CW'(acc[l]);
  end

  p_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> $countones(disp_valid) <= int'(free_cnt));

  p_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(flush)) |-> occ == $past(occ) - $past(n_iss) + $past(n_acc));

  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) <= DEPTH);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (free_cnt == CW'(DEPTH)) && (iss_valid == '0));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> iss_valid == '0);

  for (genvar k = 0; k + 1 < LANES; k++) begin : g_lane_chk
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k+1] |-> iss_valid[k] && (iss_pc[k] < iss_pc[k+1]));
  end
endmodule

// File: tb/test_age_issue_queue.sv
module test_age_issue_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic [3:0]       disp_valid, disp_a_rdy, disp_b_rdy, bc_valid;
  logic [3:0][2:0]  disp_op;
  logic [3:0][15:0] disp_pc;
  logic [3:0][5:0]  disp_dst, disp_a_tag, disp_b_tag, bc_tag;
  logic [3:0][63:0] disp_a_val, disp_b_val, bc_val;
  logic [3:0]       iss_valid;
  logic [3:0][2:0]  iss_op;
  logic [3:0][15:0] iss_pc;
  logic [3:0][5:0]  iss_dst;
  logic [3:0][63:0] iss_a_val, iss_b_val;
  logic [5:0]       free_cnt;

  age_issue_queue i_age_issue_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_pc(disp_pc), .disp_dst(disp_dst),
    .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_pc(iss_pc), .iss_dst(iss_dst),
    .iss_a_val(iss_a_val), .iss_b_val(iss_b_val), .free_cnt(free_cnt)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  bit         m_v [32];
  bit         m_ar [32];
  bit         m_br [32];
  bit         m_taken [32];
  logic [2:0]  m_op [32];
  logic [15:0] m_pc [32];
  logic [5:0]  m_dst [32];
  logic [5:0]  m_at [32];
  logic [5:0]  m_bt [32];
  logic [63:0] m_av [32];
  logic [63:0] m_bv [32];
  int pc_ctr;

  task automatic chk(string req, bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit bhit(logic [5:0] t);
    for (int l = 0; l < 4; l++) if (bc_valid[l] && bc_tag[l] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] bvalue(logic [5:0] t);
    for (int l = 0; l < 4; l++) if (bc_valid[l] && bc_tag[l] == t) return bc_val[l];
    return 64'h0;
  endfunction

  function automatic bit m_ready(int i);
    return m_v[i] && (m_ar[i] || bhit(m_at[i])) && (m_br[i] || bhit(m_bt[i]));
  endfunction

  function automatic int m_occ();
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(m_v[i]);
    return n;
  endfunction

  task automatic idle_inputs();
    flush = 1'b0;
    disp_valid = '0; disp_op = '0; disp_pc = '0; disp_dst = '0;
    disp_a_rdy = '0; disp_a_tag = '0; disp_a_val = '0;
    disp_b_rdy = '0; disp_b_tag = '0; disp_b_val = '0;
    bc_valid = '0; bc_tag = '0; bc_val = '0;
  endtask

  task automatic set_disp(int l, logic [2:0] op, logic [15:0] pc, logic [5:0] dst,
                          bit ar, logic [5:0] at, logic [63:0] av,
                          bit br, logic [5:0] bt, logic [63:0] bv);
    disp_valid[l] = 1'b1; disp_op[l] = op; disp_pc[l] = pc; disp_dst[l] = dst;
    disp_a_rdy[l] = ar; disp_a_tag[l] = at; disp_a_val[l] = av;
    disp_b_rdy[l] = br; disp_b_tag[l] = bt; disp_b_val[l] = bv;
  endtask

  task automatic set_bc(int l, logic [5:0] t, logic [63:0] v);
    bc_valid[l] = 1'b1; bc_tag[l] = t; bc_val[l] = v;
  endtask

  task automatic check_cycle(string req);
    int niss = 0;
    for (int i = 0; i < 32; i++) m_taken[i] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int best = -1;
      if (!flush)
        for (int i = 0; i < 32; i++)
          if (m_ready(i) && !m_taken[i] && (best < 0 || m_pc[i] < m_pc[best])) best = i;
      chk(req, iss_valid[k] == (best >= 0), $sformatf("lane%0d valid", k),
          64'(iss_valid[k]), 64'(best >= 0));
      if (best >= 0) begin
        logic [63:0] ea, eb;
        m_taken[best] = 1'b1;
        niss++;
        ea = m_ar[best] ? m_av[best] : bvalue(m_at[best]);
        eb = m_br[best] ? m_bv[best] : bvalue(m_bt[best]);
        chk(req, iss_pc[k] == m_pc[best], $sformatf("lane%0d pc", k), 64'(iss_pc[k]), 64'(m_pc[best]));
        chk(req, iss_op[k] == m_op[best] && iss_dst[k] == m_dst[best],
            $sformatf("lane%0d op/dst", k), {iss_op[k], iss_dst[k]}, {m_op[best], m_dst[best]});
        chk(req, iss_a_val[k] == ea, $sformatf("lane%0d opA", k), iss_a_val[k], ea);
        chk(req, iss_b_val[k] == eb, $sformatf("lane%0d opB", k), iss_b_val[k], eb);
      end
    end
    chk(req, int'(free_cnt) == 32 - m_occ() + niss, "free_cnt",
        64'(free_cnt), 64'(32 - m_occ() + niss));
  endtask

  task automatic model_update();
    if (flush) begin
      for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
      return;
    end
    for (int i = 0; i < 32; i++) begin
      if (m_taken[i]) m_v[i] = 1'b0;
      else if (m_v[i]) begin
        if (!m_ar[i] && bhit(m_at[i])) begin m_ar[i] = 1'b1; m_av[i] = bvalue(m_at[i]); end
        if (!m_br[i] && bhit(m_bt[i])) begin m_br[i] = 1'b1; m_bv[i] = bvalue(m_bt[i]); end
      end
    end
    for (int l = 0; l < 4; l++) begin
      if (disp_valid[l]) begin
        int s = -1;
        for (int i = 0; i < 32; i++) if (!m_v[i] && s < 0) s = i;
        if (s >= 0) begin
          m_v[s] = 1'b1; m_op[s] = disp_op[l]; m_pc[s] = disp_pc[l]; m_dst[s] = disp_dst[l];
          m_at[s] = disp_a_tag[l]; m_bt[s] = disp_b_tag[l];
          m_ar[s] = disp_a_rdy[l] || bhit(disp_a_tag[l]);
          m_av[s] = disp_a_rdy[l] ? disp_a_val[l] : bvalue(disp_a_tag[l]);
          m_br[s] = disp_b_rdy[l] || bhit(disp_b_tag[l]);
          m_bv[s] = disp_b_rdy[l] ? disp_b_val[l] : bvalue(disp_b_tag[l]);
        end
      end
    end
  endtask

  task automatic step(string req);
    #2;
    check_cycle(req);
    model_update();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rand_cycle();
    int budget = 32 - m_occ();
    int base = int'($urandom % 16);
    flush = ($urandom % 50) == 0;
    for (int l = 0; l < 4; l++)
      if ($urandom % 2 == 0) set_bc(l, 6'((base + 5 * l) % 16), {$urandom, $urandom});
    for (int l = 0; l < 4; l++) begin
      if (budget > 0 && $urandom % 4 != 0) begin
        budget--;
        set_disp(l, 3'($urandom % 5), 16'(pc_ctr), 6'($urandom % 64),
                 ($urandom % 2) == 0, 6'($urandom % 16), {$urandom, $urandom},
                 ($urandom % 2) == 0, 6'($urandom % 16), {$urandom, $urandom});
        pc_ctr++;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R1", free_cnt == 6'd32, "reset free_cnt", 64'(free_cnt), 64'd32);
    chk("R1", iss_valid == 4'b0, "reset iss_valid", 64'(iss_valid), 64'd0);
    @(negedge clk);

    // R2/R3: ready mulu with sign-extended immediate -5 as operand B
    set_disp(0, 3'd2, 16'd10, 6'd33, 1'b1, 6'd0, 64'd7, 1'b1, 6'd0, 64'hFFFF_FFFF_FFFF_FFFB);
    step("R2");
    step("R3");
    step("R8");

    // R4/R5/R6: six waiting entries on tag 7, lanes in reverse PC order
    for (int l = 0; l < 4; l++)
      set_disp(l, 3'(l), 16'(23 - l), 6'(40 + l), 1'b0, 6'd7, 64'd0, 1'b1, 6'd0, 64'(l + 100));
    step("R2");
    set_disp(0, 3'd4, 16'd19, 6'd50, 1'b0, 6'd7, 64'd0, 1'b1, 6'd0, 64'd5);
    set_disp(1, 3'd3, 16'd18, 6'd51, 1'b0, 6'd7, 64'd0, 1'b1, 6'd0, 64'd6);
    step("R4");
    set_bc(2, 6'd7, 64'h5555_AAAA_1234_0001);
    step("R5");
    step("R6");
    step("R8");

    // R7: broadcast in the dispatch cycle
    set_disp(2, 3'd1, 16'd30, 6'd52, 1'b0, 6'd9, 64'd0, 1'b1, 6'd0, 64'd3);
    set_bc(0, 6'd9, 64'hDEAD_0000_BEEF_0009);
    step("R7");
    step("R7");

    // R9: fill the queue, then issue and refill in the same cycle
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 4; l++)
        set_disp(l, 3'd0, 16'(40 + 4 * c + l), 6'(c * 4 + l), 1'b0, 6'd11, 64'd0,
                 1'b1, 6'd0, 64'(c));
      step("R2");
    end
    step("R9");
    set_bc(1, 6'd11, 64'h0123_4567_89AB_CDEF);
    for (int l = 0; l < 4; l++)
      set_disp(l, 3'd1, 16'(80 + l), 6'(60 + l), 1'b0, 6'd12, 64'd0, 1'b1, 6'd0, 64'd1);
    step("R9");
    step("R9");

    // R10: flush with broadcast and dispatch present
    flush = 1'b1;
    set_bc(0, 6'd12, 64'd77);
    set_disp(0, 3'd0, 16'd90, 6'd1, 1'b1, 6'd0, 64'd1, 1'b1, 6'd0, 64'd2);
    step("R10");
    chk("R10", free_cnt == 6'd32, "free after flush", 64'(free_cnt), 64'd32);
    step("R10");

    pc_ctr = 200;
    for (int n = 0; n < 3000; n++) begin
      rand_cycle();
      step("R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule